// File: doc/BRIEF.md
# CCD Line Timing Sequencer

This block produces the per-line vertical clock patterns and the horizontal blanking signal for reading out a CCD sensor. A pulse on `hd` starts a line: the pixel counter restarts at zero, the odd/even line flag flips, and the configuration written since the previous line becomes active. A pulse on `vd` starts a field, so that the next line is an odd line.

During each line, one stored vertical pattern is replayed on the six vertical outputs. The number of replays comes from a repeat count, and that count can be chosen by line parity. The blanking output is built from six programmable toggle positions. An alternation mode gives the first two positions to odd lines and the other four to even lines. On a line flagged as a sensor-gate line, a second stored pattern takes over the vertical outputs at a start pixel. That start pixel is read from the second pattern's own length field. The second pattern runs once and then holds its levels until the line ends.

Configuration arrives on a simple parallel write port. Every write lands in a shadow copy, and the shadow copy moves into the live copy only when `hd` is sampled high.

Top module: `ccd_line_seq`

## Requirements
- R1: After reset, `pix_cnt` is all ones, `line_odd` is 0, `hblk` is 0 and `v_out` is 0. Every live and shadow field is zero, except the six blanking toggle positions, which reset to all ones.
- R2: Sampling `hd` high without `vd` inverts `line_odd`. Sampling `vd` high alone clears `line_odd`. Sampling both high together sets `line_odd` to 1. In all three cases the new value is visible in the next cycle.
- R3: Writes change only the shadow copy. The live copy takes the shadow contents at an edge where `hd` is high. A write at that same edge takes effect only at the following `hd`.
- R4: With live pattern length L>0 and repeat count N, at pixel p < N*L each vertical output v is: start[v] XOR (p mod L >= t1[v]) XOR (p mod L >= t2[v]). Here start, t1 and t2 belong to the pattern picked by the sequence select. From p >= N*L, `v_out` equals the idle levels.
- R5: When repeat alternation is on, N is the even-line count on lines with `line_odd`=0 and the odd-line count on odd lines. When it is off, the odd-line count applies to every line. The pattern is the same in both cases.
- R6: A repeat count of 0, or a selected pattern length of 0, keeps `v_out` at the idle levels for the whole line.
- R7: `hblk` is the XOR, over the enabled toggles i, of (`pix_cnt` >= pos[i]). A toggle whose position is all ones is never counted, so `hblk` is 0 at the start of a line unless a toggle sits at 0.
- R8: With blanking alternation on, odd lines use only toggles 0 and 1, and even lines use only toggles 2 to 5. With it off, all six toggles are used on every line.
- R9: On a line that began with `vsg_line` high, let S be the length field of the second-select pattern. For `pix_cnt` >= S, each output v is: start2[v] XOR (ph >= t1_2[v]) XOR (ph >= t2_2[v]), with ph = `pix_cnt` - S. This takes priority over the first group, runs once and lasts until the next `hd`.
- R10: `pix_cnt` reads 0 in the cycle after the edge where `hd` is high. It then counts up by one per cycle and saturates at all ones. While it is saturated, the pattern state is frozen at its saturated-pixel value.
- R11: Write map (address, data bits):
  - 0x00 control: bit0 repeat alternation, bit1 blanking alternation, bits[9:8] sequence select, bits[13:12] second select.
  - 0x01 odd-line repeat count; 0x02 even-line repeat count; 0x03 idle levels.
  - 0x10+i blanking toggle i.
  - Pattern p has base 0x20+16p: +0 length, +1 start levels, +2+2v t1 of output v, +3+2v t2 of output v.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd | input | 1 | Line start pulse |
| vd | input | 1 | Field start pulse |
| vsg_line | input | 1 | Marks the starting line as a sensor-gate line, sampled with `hd` |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| v_out | output | NUM_V | Vertical clock outputs |
| hblk | output | 1 | Horizontal blanking |
| line_odd | output | 1 | 1 on odd lines |
| pix_cnt | output | PIX_W | Pixel position in the line |

## Verification
The bench builds the block with PIX_W=8 and VLEN_W=6, and keeps four pattern slots and six outputs. With these values, a 300-cycle line carries the pixel counter into saturation while a long repeated pattern is still running, so the freeze behaviour can be observed. The four slots also make room for a zero-length slot as the main pattern, and for a second group that starts both inside and after the first group's span.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  localparam int ADDR_W       = 8;
  localparam int DATA_W       = 16;
  localparam int NUM_HTOG     = 6;
  localparam int HTOG_ODD_CNT = 2;
  localparam int PAT_STRIDE   = 16;

  localparam logic [ADDR_W-1:0] A_CTRL      = 8'h00;
  localparam logic [ADDR_W-1:0] A_REP_ODD   = 8'h01;
  localparam logic [ADDR_W-1:0] A_REP_EVEN  = 8'h02;
  localparam logic [ADDR_W-1:0] A_IDLE      = 8'h03;
  localparam logic [ADDR_W-1:0] A_HTOG_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] A_PAT_BASE  = 8'h20;

  localparam int CTRL_REPALT_BIT = 0;
  localparam int CTRL_HALT_BIT   = 1;
  localparam int CTRL_SEQ_LSB    = 8;
  localparam int CTRL_SEC_LSB    = 12;

  function automatic logic [ADDR_W-1:0] pat_addr(input int p, input int off);
    return A_PAT_BASE + ADDR_W'(p * PAT_STRIDE + off);
  endfunction

  function automatic logic [ADDR_W-1:0] htog_addr(input int i);
    return A_HTOG_BASE + ADDR_W'(i);
  endfunction
endpackage

// File: rtl/ccd_seq_regs.sv
module ccd_seq_regs import ccd_seq_pkg::*; #(
  parameter int NUM_V   = 6,
  parameter int NUM_PAT = 4,
  parameter int PIX_W   = 12,
  parameter int VLEN_W  = 10,
  parameter int REP_W   = 4,
  parameter int SEL_W   = 2
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       hd,
  input  logic                                       wr_en,
  input  logic [ADDR_W-1:0]                          wr_addr,
  input  logic [DATA_W-1:0]                          wr_data,
  output logic                                       rep_alt,
  output logic                                       hblk_alt,
  output logic [SEL_W-1:0]                           seq_sel,
  output logic [SEL_W-1:0]                           sec_sel,
  output logic [REP_W-1:0]                           rep_odd,
  output logic [REP_W-1:0]                           rep_even,
  output logic [NUM_V-1:0]                           idle_lvl,
  output logic [NUM_HTOG-1:0][PIX_W-1:0]             htog,
  output logic [NUM_PAT-1:0][VLEN_W-1:0]             pat_len,
  output logic [NUM_PAT-1:0][NUM_V-1:0]              pat_start,
  output logic [NUM_PAT-1:0][NUM_V-1:0][VLEN_W-1:0]  pat_t1,
  output logic [NUM_PAT-1:0][NUM_V-1:0][VLEN_W-1:0]  pat_t2
);
  typedef struct packed {
    logic                                      rep_alt;
    logic                                      hblk_alt;
    logic [SEL_W-1:0]                          seq_sel;
    logic [SEL_W-1:0]                          sec_sel;
    logic [REP_W-1:0]                          rep_odd;
    logic [REP_W-1:0]                          rep_even;
    logic [NUM_V-1:0]                          idle_lvl;
    logic [NUM_HTOG-1:0][PIX_W-1:0]            htog;
    logic [NUM_PAT-1:0][VLEN_W-1:0]            len;
    logic [NUM_PAT-1:0][NUM_V-1:0]             start;
    logic [NUM_PAT-1:0][NUM_V-1:0][VLEN_W-1:0] t1;
    logic [NUM_PAT-1:0][NUM_V-1:0][VLEN_W-1:0] t2;
  } cfg_t;

  function automatic cfg_t cfg_rst();
    cfg_t c;
    c      = '0;
    c.htog = '1;
    return c;
  endfunction

  cfg_t sh_q, sh_d, lv_q, lv_d;
  logic unused_bits;
  assign unused_bits = ^wr_data;

  // shadow next state: decode one write per cycle
  always_comb begin
    sh_d = sh_q;
    if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        sh_d.rep_alt  = wr_data[CTRL_REPALT_BIT];
        sh_d.hblk_alt = wr_data[CTRL_HALT_BIT];
        sh_d.seq_sel  = wr_data[CTRL_SEQ_LSB +: SEL_W];
        sh_d.sec_sel  = wr_data[CTRL_SEC_LSB +: SEL_W];
      end
      if (wr_addr == A_REP_ODD)  sh_d.rep_odd  = wr_data[REP_W-1:0];
      if (wr_addr == A_REP_EVEN) sh_d.rep_even = wr_data[REP_W-1:0];
      if (wr_addr == A_IDLE)     sh_d.idle_lvl = wr_data[NUM_V-1:0];
      for (int i = 0; i < NUM_HTOG; i++) begin
        if (wr_addr == htog_addr(i)) sh_d.htog[i] = wr_data[PIX_W-1:0];
      end
      for (int p = 0; p < NUM_PAT; p++) begin
        if (wr_addr == pat_addr(p, 0)) sh_d.len[p]   = wr_data[VLEN_W-1:0];
        if (wr_addr == pat_addr(p, 1)) sh_d.start[p] = wr_data[NUM_V-1:0];
        for (int v = 0; v < NUM_V; v++) begin
          if (wr_addr == pat_addr(p, 2 + 2*v)) sh_d.t1[p][v] = wr_data[VLEN_W-1:0];
          if (wr_addr == pat_addr(p, 3 + 2*v)) sh_d.t2[p][v] = wr_data[VLEN_W-1:0];
        end
      end
    end
  end

  // live copy follows the shadow only at a line boundary
  always_comb begin
    lv_d = lv_q;
    if (hd) lv_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= cfg_rst();
      lv_q <= cfg_rst();
    end else begin
      sh_q <= sh_d;
      lv_q <= lv_d;
    end
  end

  assign rep_alt   = lv_q.rep_alt;
  assign hblk_alt  = lv_q.hblk_alt;
  assign seq_sel   = lv_q.seq_sel;
  assign sec_sel   = lv_q.sec_sel;
  assign rep_odd   = lv_q.rep_odd;
  assign rep_even  = lv_q.rep_even;
  assign idle_lvl  = lv_q.idle_lvl;
  assign htog      = lv_q.htog;
  assign pat_len   = lv_q.len;
  assign pat_start = lv_q.start;
  assign pat_t1    = lv_q.t1;
  assign pat_t2    = lv_q.t2;

  AST_LIVE_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
    !hd |=> $stable(lv_q)); // R3
endmodule

// File: rtl/ccd_line_ctr.sv
module ccd_line_ctr #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hd,
  input  logic             vd,
  input  logic             vsg_line,
  output logic [PIX_W-1:0] pix,
  output logic             pix_max,
  output logic             line_odd,
  output logic             vsg_live
);
  localparam logic [PIX_W-1:0] PIX_TOP = '1;

  logic [PIX_W-1:0] pix_q, pix_d;
  logic             odd_q, odd_d;
  logic             vsg_q, vsg_d;

  always_comb begin
    pix_d = pix_q;
    odd_d = odd_q;
    vsg_d = vsg_q;
    if (hd) begin
      pix_d = '0;
      odd_d = vd ? 1'b1 : ~odd_q;
      vsg_d = vsg_line;
    end else begin
      if (pix_q != PIX_TOP) pix_d = pix_q + PIX_W'(1);
      if (vd) odd_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= PIX_TOP;
      odd_q <= 1'b0;
      vsg_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
      odd_q <= odd_d;
      vsg_q <= vsg_d;
    end
  end

  assign pix      = pix_q;
  assign pix_max  = (pix_q == PIX_TOP);
  assign line_odd = odd_q;
  assign vsg_live = vsg_q;

  AST_PIX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hd |=> pix == '0); // R10
  AST_PIX_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    !hd && pix_max |=> pix_max); // R10
  AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    hd && !vd |=> line_odd != $past(line_odd)); // R2
  AST_FIELD_FIRST_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    hd && vd |=> line_odd); // R2
  AST_FIELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    vd && !hd |=> !line_odd); // R2
endmodule

// File: rtl/ccd_vpat_gen.sv
module ccd_vpat_gen #(
  parameter int NUM_V   = 6,
  parameter int NUM_PAT = 4,
  parameter int PIX_W   = 12,
  parameter int VLEN_W  = 10,
  parameter int REP_W   = 4,
  parameter int SEL_W   = 2
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       hd,
  input  logic [PIX_W-1:0]                           pix,
  input  logic                                       pix_max,
  input  logic                                       line_odd,
  input  logic                                       vsg_live,
  input  logic                                       rep_alt,
  input  logic [SEL_W-1:0]                           seq_sel,
  input  logic [SEL_W-1:0]                           sec_sel,
  input  logic [REP_W-1:0]                           rep_odd,
  input  logic [REP_W-1:0]                           rep_even,
  input  logic [NUM_V-1:0]                           idle_lvl,
  input  logic [NUM_PAT-1:0][VLEN_W-1:0]             pat_len,
  input  logic [NUM_PAT-1:0][NUM_V-1:0]              pat_start,
  input  logic [NUM_PAT-1:0][NUM_V-1:0][VLEN_W-1:0]  pat_t1,
  input  logic [NUM_PAT-1:0][NUM_V-1:0][VLEN_W-1:0]  pat_t2,
  output logic [NUM_V-1:0]                           v_out
);
  logic [VLEN_W-1:0] ph_q, ph_d;
  logic [REP_W-1:0]  rc_q, rc_d;
  logic [VLEN_W-1:0] sel_len;
  logic [REP_W-1:0]  n_rep;
  logic              grp_on;
  logic [PIX_W-1:0]  sec_start;
  logic [PIX_W-1:0]  ph2;
  logic              sec_on;
  logic [NUM_V-1:0]  lvl1, lvl2;

  assign sel_len   = pat_len[seq_sel];
  assign n_rep     = (rep_alt && !line_odd) ? rep_even : rep_odd;
  assign grp_on    = (rc_q < n_rep) && (sel_len != '0);
  assign sec_start = PIX_W'(pat_len[sec_sel]);
  assign sec_on    = vsg_live && (pix >= sec_start);
  assign ph2       = pix - sec_start;

  // phase within the pattern and count of finished replays
  always_comb begin
    ph_d = ph_q;
    rc_d = rc_q;
    if (hd) begin
      ph_d = '0;
      rc_d = '0;
    end else if (grp_on && !pix_max) begin
      if (ph_q == sel_len - VLEN_W'(1)) begin
        ph_d = '0;
        rc_d = rc_q + REP_W'(1);
      end else begin
        ph_d = ph_q + VLEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      rc_q <= '0;
    end else begin
      ph_q <= ph_d;
      rc_q <= rc_d;
    end
  end

  for (genvar v = 0; v < NUM_V; v++) begin : g_lvl
    assign lvl1[v] = pat_start[seq_sel][v]
                   ^ (ph_q >= pat_t1[seq_sel][v])
                   ^ (ph_q >= pat_t2[seq_sel][v]);
    assign lvl2[v] = pat_start[sec_sel][v]
                   ^ (ph2 >= PIX_W'(pat_t1[sec_sel][v]))
                   ^ (ph2 >= PIX_W'(pat_t2[sec_sel][v]));
  end

  always_comb begin
    if (sec_on)      v_out = lvl2;
    else if (grp_on) v_out = lvl1;
    else             v_out = idle_lvl;
  end

  AST_PHASE_IN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    grp_on |-> ph_q < sel_len); // R4
  AST_REPEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rc_q <= n_rep); // R5
  AST_SECOND_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_on && !hd |=> sec_on); // R9
endmodule

// File: rtl/ccd_hblk_gen.sv
module ccd_hblk_gen import ccd_seq_pkg::*; #(
  parameter int PIX_W = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           hd,
  input  logic [PIX_W-1:0]               pix,
  input  logic                           pix_max,
  input  logic                           line_odd,
  input  logic                           hblk_alt,
  input  logic [NUM_HTOG-1:0][PIX_W-1:0] htog,
  output logic                           hblk
);
  localparam logic [PIX_W-1:0] TOG_OFF = '1;

  logic [NUM_HTOG-1:0] hit;

  for (genvar i = 0; i < NUM_HTOG; i++) begin : g_tog
    localparam logic FOR_ODD = (i < HTOG_ODD_CNT);
    logic en;
    assign en     = !hblk_alt || (line_odd == FOR_ODD);
    assign hit[i] = en && (htog[i] != TOG_OFF) && (pix >= htog[i]);
  end

  assign hblk = ^hit;

  AST_HBLK_FROZEN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !hd && pix_max |=> $stable(hblk)); // R7
endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq import ccd_seq_pkg::*; #(
  parameter int NUM_V   = 6,
  parameter int NUM_PAT = 4,
  parameter int PIX_W   = 12,
  parameter int VLEN_W  = 10,
  parameter int REP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd,
  input  logic              vd,
  input  logic              vsg_line,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_V-1:0]  v_out,
  output logic              hblk,
  output logic              line_odd,
  output logic [PIX_W-1:0]  pix_cnt
);
  localparam int SEL_W = $clog2(NUM_PAT);

  logic                                      rep_alt, hblk_alt;
  logic [SEL_W-1:0]                          seq_sel, sec_sel;
  logic [REP_W-1:0]                          rep_odd, rep_even;
  logic [NUM_V-1:0]                          idle_lvl;
  logic [NUM_HTOG-1:0][PIX_W-1:0]            htog;
  logic [NUM_PAT-1:0][VLEN_W-1:0]            pat_len;
  logic [NUM_PAT-1:0][NUM_V-1:0]             pat_start;
  logic [NUM_PAT-1:0][NUM_V-1:0][VLEN_W-1:0] pat_t1, pat_t2;
  logic [PIX_W-1:0]                          pix;
  logic                                      pix_max, vsg_live;

  ccd_seq_regs #(.NUM_V(NUM_V), .NUM_PAT(NUM_PAT), .PIX_W(PIX_W), .VLEN_W(VLEN_W),
                 .REP_W(REP_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .hd(hd), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rep_alt(rep_alt), .hblk_alt(hblk_alt), .seq_sel(seq_sel), .sec_sel(sec_sel),
    .rep_odd(rep_odd), .rep_even(rep_even), .idle_lvl(idle_lvl), .htog(htog),
    .pat_len(pat_len), .pat_start(pat_start), .pat_t1(pat_t1), .pat_t2(pat_t2));

  ccd_line_ctr #(.PIX_W(PIX_W)) u_line (
    .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .vsg_line(vsg_line),
    .pix(pix), .pix_max(pix_max), .line_odd(line_odd), .vsg_live(vsg_live));

  ccd_vpat_gen #(.NUM_V(NUM_V), .NUM_PAT(NUM_PAT), .PIX_W(PIX_W), .VLEN_W(VLEN_W),
                 .REP_W(REP_W), .SEL_W(SEL_W)) u_vpat (
    .clk(clk), .rst_n(rst_n), .hd(hd), .pix(pix), .pix_max(pix_max),
    .line_odd(line_odd), .vsg_live(vsg_live), .rep_alt(rep_alt),
    .seq_sel(seq_sel), .sec_sel(sec_sel), .rep_odd(rep_odd), .rep_even(rep_even),
    .idle_lvl(idle_lvl), .pat_len(pat_len), .pat_start(pat_start),
    .pat_t1(pat_t1), .pat_t2(pat_t2), .v_out(v_out));

  ccd_hblk_gen #(.PIX_W(PIX_W)) u_hblk (
    .clk(clk), .rst_n(rst_n), .hd(hd), .pix(pix), .pix_max(pix_max),
    .line_odd(line_odd), .hblk_alt(hblk_alt), .htog(htog), .hblk(hblk));

  assign pix_cnt = pix;
endmodule

// File: tb/ccd_line_seq_test.sv
module ccd_line_seq_test;
  localparam int NV    = 6;
  localparam int NP    = 4;
  localparam int PW    = 8;
  localparam int VW    = 6;
  localparam int PMAX  = (1 << PW) - 1;
  localparam int VMASK = (1 << VW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hd = 1'b0, vd = 1'b0, vsg_line = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [NV-1:0] v_out;
  logic          hblk, line_odd;
  logic [PW-1:0] pix_cnt;

  ccd_line_seq #(.NUM_V(NV), .NUM_PAT(NP), .PIX_W(PW), .VLEN_W(VW), .REP_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .vsg_line(vsg_line),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .v_out(v_out), .hblk(hblk), .line_odd(line_odd), .pix_cnt(pix_cnt));

  always #10 clk = ~clk;

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit    run_chk = 0;

  // reference state
  int sh_ralt, sh_halt, sh_seq, sh_sec, sh_ro, sh_re, sh_idle;
  int lv_ralt, lv_halt, lv_seq, lv_sec, lv_ro, lv_re, lv_idle;
  int sh_ht[6], lv_ht[6];
  int sh_len[NP], sh_st[NP], lv_len[NP], lv_st[NP];
  int sh_t1[NP][NV], sh_t2[NP][NV], lv_t1[NP][NV], lv_t2[NP][NV];
  int m_pix, m_odd, m_vsg;

  task automatic model_reset();
    sh_ralt = 0; sh_halt = 0; sh_seq = 0; sh_sec = 0; sh_ro = 0; sh_re = 0; sh_idle = 0;
    lv_ralt = 0; lv_halt = 0; lv_seq = 0; lv_sec = 0; lv_ro = 0; lv_re = 0; lv_idle = 0;
    for (int i = 0; i < 6; i++) begin sh_ht[i] = PMAX; lv_ht[i] = PMAX; end
    for (int p = 0; p < NP; p++) begin
      sh_len[p] = 0; sh_st[p] = 0; lv_len[p] = 0; lv_st[p] = 0;
      for (int v = 0; v < NV; v++) begin
        sh_t1[p][v] = 0; sh_t2[p][v] = 0; lv_t1[p][v] = 0; lv_t2[p][v] = 0;
      end
    end
    m_pix = PMAX; m_odd = 0; m_vsg = 0;
  endtask

  task automatic model_write(int a, int d);
    if (a == 0) begin
      sh_ralt = d & 1; sh_halt = (d >> 1) & 1; sh_seq = (d >> 8) & 3; sh_sec = (d >> 12) & 3;
    end
    if (a == 1) sh_ro = d & 15;
    if (a == 2) sh_re = d & 15;
    if (a == 3) sh_idle = d & 63;
    if (a >= 16 && a < 22) sh_ht[a-16] = d & PMAX;
    if (a >= 32 && a < 32 + 16*NP) begin
      int p, o;
      p = (a - 32) / 16; o = (a - 32) % 16;
      if (o == 0) sh_len[p] = d & VMASK;
      if (o == 1) sh_st[p] = d & 63;
      if (o >= 2 && o < 2 + 2*NV) begin
        if (o % 2 == 0) sh_t1[p][(o-2)/2] = d & VMASK;
        else            sh_t2[p][(o-2)/2] = d & VMASK;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      if (hd) begin
        lv_ralt = sh_ralt; lv_halt = sh_halt; lv_seq = sh_seq; lv_sec = sh_sec;
        lv_ro = sh_ro; lv_re = sh_re; lv_idle = sh_idle; lv_ht = sh_ht;
        lv_len = sh_len; lv_st = sh_st; lv_t1 = sh_t1; lv_t2 = sh_t2;
      end
      if (wr_en) model_write(int'(wr_addr), int'(wr_data));
      if (hd) begin
        m_pix = 0; m_odd = vd ? 1 : 1 - m_odd; m_vsg = vsg_line;
      end else begin
        if (m_pix < PMAX) m_pix++;
        if (vd) m_odd = 0;
      end
    end
  end

  function automatic logic [NV-1:0] exp_v();
    logic [NV-1:0] e;
    int l, n, s, ph;
    l = lv_len[lv_seq];
    n = (lv_ralt != 0 && m_odd == 0) ? lv_re : lv_ro;
    s = lv_len[lv_sec];
    for (int v = 0; v < NV; v++) begin
      if (m_vsg != 0 && m_pix >= s) begin
        ph = m_pix - s;
        e[v] = ((lv_st[lv_sec] >> v) & 1) ^ (ph >= lv_t1[lv_sec][v]) ^ (ph >= lv_t2[lv_sec][v]);
      end else if (l != 0 && m_pix < n * l) begin
        ph = m_pix % l;
        e[v] = ((lv_st[lv_seq] >> v) & 1) ^ (ph >= lv_t1[lv_seq][v]) ^ (ph >= lv_t2[lv_seq][v]);
      end else begin
        e[v] = (lv_idle >> v) & 1;
      end
    end
    return e;
  endfunction

  function automatic logic exp_hblk();
    logic h = 1'b0;
    for (int i = 0; i < 6; i++) begin
      bit en;
      en = (lv_halt == 0) || (m_odd != 0 ? (i < 2) : (i >= 2));
      if (en && lv_ht[i] != PMAX && m_pix >= lv_ht[i]) h = ~h;
    end
    return h;
  endfunction

  task automatic check_bit(string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s at pix %0d: actual %0h expected %0h", cur_req, what, m_pix, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_chk && rst_n) begin
      check_bit("v_out", 16'(v_out), 16'(exp_v()));
      check_bit("hblk", 16'(hblk), 16'(exp_hblk()));
      check_bit("line_odd", 16'(line_odd), 16'(m_odd));
      check_bit("pix_cnt", 16'(pix_cnt), 16'(m_pix));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'(a); wr_data = 16'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_line(int n, bit g);
    @(negedge clk); hd = 1'b1; vsg_line = g;
    @(negedge clk); hd = 1'b0; vsg_line = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic set_ctrl(int ralt, int halt, int seq, int sec);
    wr(0, ralt | (halt << 1) | (seq << 8) | (sec << 12));
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_chk = 1;
    // R1: reset state observed for a few cycles
    repeat (4) @(negedge clk);

    // R11: program every field through the write map, no hd yet
    cur_req = "R11";
    for (int v = 0; v < NV; v++) begin
      wr(32 + 2 + 2*v, v);       wr(32 + 3 + 2*v, v + 3);
      wr(48 + 2 + 2*v, v % 3);   wr(48 + 3 + 2*v, 4);
      wr(64 + 2 + 2*v, 2 + v);   wr(64 + 3 + 2*v, 10 + v);
      wr(80 + 2 + 2*v, 1);       wr(80 + 3 + 2*v, 2);
    end
    wr(32, 7);  wr(33, 6'b100101);
    wr(48, 5);  wr(49, 6'b011010);
    wr(64, 40); wr(65, 6'b110011);
    wr(80, 0);  wr(81, 6'b111111);
    wr(1, 3); wr(2, 5); wr(3, 6'b001100);
    wr(16, 5); wr(17, 30); wr(18, 10); wr(19, 20); wr(20, 50); wr(21, PMAX);
    // R3: nothing above is live until hd
    cur_req = "R3";
    set_ctrl(0, 0, 0, 2);
    repeat (5) @(negedge clk);

    // R4 and R5 (alternation off: odd count on every line)
    cur_req = "R4";
    run_line(60, 0); run_line(60, 0);
    cur_req = "R5";
    set_ctrl(1, 0, 0, 2);
    run_line(60, 0); run_line(60, 0); run_line(60, 0); run_line(60, 0);

    // R7: all six toggles, one disabled, one at position 0
    cur_req = "R7";
    run_line(70, 0);
    wr(21, 0);
    run_line(70, 0); run_line(70, 0);
    // R8: blanking alternation
    cur_req = "R8";
    set_ctrl(1, 1, 0, 2);
    run_line(70, 0); run_line(70, 0); run_line(70, 0);
    wr(21, PMAX);

    // R6: zero repeats, then zero-length pattern
    cur_req = "R6";
    wr(1, 0); wr(2, 0);
    run_line(50, 0); run_line(50, 0);
    wr(1, 3); wr(2, 5); set_ctrl(0, 0, 3, 2);
    run_line(50, 0); run_line(50, 0);

    // R9: second group after and inside the first group's span
    cur_req = "R9";
    set_ctrl(1, 0, 0, 2);
    run_line(80, 1); run_line(80, 0); run_line(80, 1);
    set_ctrl(1, 0, 0, 1);
    run_line(80, 1); run_line(80, 1);

    // R2: field pulses alone and together with hd
    cur_req = "R2";
    set_ctrl(1, 1, 0, 2);
    run_line(40, 0);
    @(negedge clk); vd = 1'b1; @(negedge clk); vd = 1'b0;
    repeat (5) @(negedge clk);
    run_line(40, 0); run_line(40, 0);
    @(negedge clk); hd = 1'b1; vd = 1'b1; @(negedge clk); hd = 1'b0; vd = 1'b0;
    repeat (40) @(negedge clk);
    run_line(40, 0);

    // R3: write during a line and at the same edge as hd
    cur_req = "R3";
    repeat (3) @(negedge clk);
    wr(3, 6'b110000);
    repeat (10) @(negedge clk);
    @(negedge clk); hd = 1'b1; wr_en = 1'b1; wr_addr = 8'd1; wr_data = 16'd1;
    @(negedge clk); hd = 1'b0; wr_en = 1'b0;
    repeat (40) @(negedge clk);
    run_line(40, 0); run_line(40, 0);

    // R10: long pattern across pixel saturation
    cur_req = "R10";
    wr(1, 15); wr(2, 15); set_ctrl(0, 0, 2, 0);
    run_line(300, 0);
    run_line(300, 1);
    run_line(20, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule